// File: doc/BRIEF.md
# Host Parallel Control Register Port

This block connects a 16-bit parallel host bus with a 9-bit address to the control state of a signal-processing core. The host drives an active-low chip enable, an active-low write strobe and an active-low read strobe. The block passes these strobes through a two-flop synchronizer into the core clock domain. It decodes a 512-word address space, stores the control and DC offset words, and drives read data together with an output-enable. The output-enable lets the data pins be modelled as a tristate bus.

The lower half of the space holds these locations:
- fourteen read/write control words;
- a touch address that fires a one-clock sync pulse;
- a read-only test status word;
- four DC offset words;
- a range of unused addresses.

The upper half is split by direction. A write there goes to a lookup memory port, and a read there returns a capture memory port at the same offset. If the read strobe is tied low, the interface switches to a select-plus-direction protocol. In that mode chip enable frames the access and the write strobe acts as the read/write line.

Top module: `host_ctrl_if`

## Requirements
- R1: Normal write. With ce_ni low and re_ni high, a low-then-high pulse on we_ni commits wdata_i to addr_i. The commit happens on the synchronized rising edge of we_ni, and the stored value is visible on the register outputs within four clock cycles of the edge. Address and data must stay stable until then.
- R2: Legacy write. While re_ni is low, the interface is in legacy mode. A rising edge of ce_ni while we_ni is low commits wdata_i to addr_i. A rising edge of ce_ni while we_ni is high writes nothing.
- R3: oe_o is high only when the synchronized ce_ni is low, the synchronized re_ni is low and the synchronized we_ni is high. oe_o follows the pins with two cycles of latency. rdata_o is zero whenever oe_o is low.
- R4: Addresses 0 to 13 are 16-bit read/write control words. Word k appears on ctrl_regs_o[16k+15:16k].
- R5: A write to address 14 raises pulse_o for exactly one clock cycle. It stores nothing, and the address reads as zero.
- R6: Address 15 reads test_stat_i. Writes to it change no stored word.
- R7: Addresses 16 to 19 are read/write DC offset words, in the order I in, Q in, I out, Q out. Word j appears on dc_regs_o[16j+15:16j].
- R8: Addresses 20 to 255 read as zero. Writes to them change no stored word.
- R9: A write to addresses 256 to 511 raises lut_we_o for one cycle, with lut_addr_o equal to addr_i[7:0] and lut_wdata_o equal to the written data. It changes no stored word.
- R10: A read from addresses 256 to 511 returns cap_rdata_i, with cap_addr_o equal to addr_i[7:0].
- R11: rst_ni low clears all stored words and holds oe_o, pulse_o and lut_we_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ce_ni | input | 1 | Chip enable, active low |
| we_ni | input | 1 | Write strobe; read/write line in legacy mode |
| re_ni | input | 1 | Read strobe; held low selects legacy mode |
| addr_i | input | 9 | Host address |
| wdata_i | input | 16 | Host write data |
| rdata_o | output | 16 | Read data, zero when not driving |
| oe_o | output | 1 | Data bus output-enable |
| ctrl_regs_o | output | 224 | Fourteen control words, word k at bits 16k+15:16k |
| dc_regs_o | output | 64 | Four DC offset words |
| pulse_o | output | 1 | One-shot sync pulse |
| test_stat_i | input | 16 | Test status word shown at address 15 |
| lut_we_o | output | 1 | Lookup memory write enable |
| lut_addr_o | output | 8 | Lookup memory write address |
| lut_wdata_o | output | 16 | Lookup memory write data |
| cap_addr_o | output | 8 | Capture memory read address |
| cap_rdata_i | input | 16 | Capture memory read data |

## Verification
Each fault in the control state shows up at the ports within a few clock cycles.

- A decode slip puts a wrong word on rdata_o as soon as oe_o rises, about two clocks after the strobes change.
- A write that lands in the wrong slot alters ctrl_regs_o or dc_regs_o three clocks after the strobe edge, without any read.
- A broken edge detector shows up in two ways: pulse_o or lut_we_o stays high for two cycles, or it never fires.
- A wrong mode select shows up as a legacy access that commits nothing, or as a normal read that commits a spurious write.

// File: rtl/hcif_pkg.sv
package hcif_pkg;
  typedef enum logic [2:0] {
    K_CTRL,
    K_PULSE,
    K_TEST,
    K_DC,
    K_NONE,
    K_MEM
  } akind_e;

  typedef struct packed {
    logic ce_n;
    logic we_n;
    logic re_n;
  } strobe_t;
endpackage

// File: rtl/hcif_sync.sv
module hcif_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  // strobes are active low: reset to the idle (high) level
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= '1;
    else         stg_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '1;
      else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/hcif_decode.sv
module hcif_decode
  import hcif_pkg::*;
#(
  parameter int AW     = 9,
  parameter int N_CTRL = 14,
  parameter int N_DC   = 4,
  parameter int IDX_W  = 4
) (
  input  logic [AW-1:0]    addr_i,
  output akind_e           kind_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [AW-1:0] PULSE_A = AW'(N_CTRL);
  localparam logic [AW-1:0] TEST_A  = AW'(N_CTRL + 1);
  localparam logic [AW-1:0] DC_LO   = AW'(N_CTRL + 2);
  localparam logic [AW-1:0] DC_HI   = AW'(N_CTRL + 2 + N_DC);

  logic [AW-1:0] dc_off;
  assign dc_off = addr_i - DC_LO;

  always_comb begin
    kind_o = K_NONE;
    idx_o  = '0;
    if (addr_i[AW-1]) begin
      kind_o = K_MEM;
    end else if (addr_i < PULSE_A) begin
      kind_o = K_CTRL;
      idx_o  = addr_i[IDX_W-1:0];
    end else if (addr_i == PULSE_A) begin
      kind_o = K_PULSE;
    end else if (addr_i == TEST_A) begin
      kind_o = K_TEST;
    end else if (addr_i < DC_HI) begin
      kind_o = K_DC;
      idx_o  = dc_off[IDX_W-1:0];
    end
  end
endmodule

// File: rtl/hcif_regfile.sv
module hcif_regfile
  import hcif_pkg::*;
#(
  parameter int DW     = 16,
  parameter int N_CTRL = 14,
  parameter int N_DC   = 4,
  parameter int IDX_W  = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  akind_e             kind_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [N_CTRL*DW-1:0] ctrl_o,
  output logic [N_DC*DW-1:0]   dc_o
);
  for (genvar k = 0; k < N_CTRL; k++) begin : g_ctrl
    logic [DW-1:0] word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) word_q <= '0;
      else if (wr_i && kind_i == K_CTRL && idx_i == IDX_W'(k)) word_q <= wdata_i;
    end
    assign ctrl_o[k*DW +: DW] = word_q;
  end

  for (genvar j = 0; j < N_DC; j++) begin : g_dc
    logic [DW-1:0] word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) word_q <= '0;
      else if (wr_i && kind_i == K_DC && idx_i == IDX_W'(j)) word_q <= wdata_i;
    end
    assign dc_o[j*DW +: DW] = word_q;
  end
endmodule

// File: rtl/hcif_rdmux.sv
module hcif_rdmux
  import hcif_pkg::*;
#(
  parameter int DW     = 16,
  parameter int N_CTRL = 14,
  parameter int N_DC   = 4,
  parameter int IDX_W  = 4
) (
  input  logic                 oe_i,
  input  akind_e               kind_i,
  input  logic [IDX_W-1:0]     idx_i,
  input  logic [N_CTRL*DW-1:0] ctrl_i,
  input  logic [N_DC*DW-1:0]   dc_i,
  input  logic [DW-1:0]        test_i,
  input  logic [DW-1:0]        mem_i,
  output logic [DW-1:0]        rdata_o
);
  logic [DW-1:0] sel;

  always_comb begin
    unique case (kind_i)
      K_CTRL:  sel = ctrl_i[int'(idx_i)*DW +: DW];
      K_DC:    sel = dc_i[int'(idx_i)*DW +: DW];
      K_TEST:  sel = test_i;
      K_MEM:   sel = mem_i;
      default: sel = '0;
    endcase
  end

  assign rdata_o = oe_i ? sel : '0;
endmodule

// File: rtl/host_ctrl_if.sv
module host_ctrl_if
  import hcif_pkg::*;
#(
  parameter int DW          = 16,
  parameter int AW          = 9,
  parameter int N_CTRL      = 14,
  parameter int N_DC        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ce_ni,
  input  logic                 we_ni,
  input  logic                 re_ni,
  input  logic [AW-1:0]        addr_i,
  input  logic [DW-1:0]        wdata_i,
  output logic [DW-1:0]        rdata_o,
  output logic                 oe_o,
  output logic [N_CTRL*DW-1:0] ctrl_regs_o,
  output logic [N_DC*DW-1:0]   dc_regs_o,
  output logic                 pulse_o,
  input  logic [DW-1:0]        test_stat_i,
  output logic                 lut_we_o,
  output logic [AW-2:0]        lut_addr_o,
  output logic [DW-1:0]        lut_wdata_o,
  output logic [AW-2:0]        cap_addr_o,
  input  logic [DW-1:0]        cap_rdata_i
);
  localparam int IDX_W = $clog2((N_CTRL > N_DC) ? N_CTRL : N_DC);
  localparam int MW    = AW - 1;

  strobe_t pins, strb_s, strb_q;
  assign pins = '{ce_n: ce_ni, we_n: we_ni, re_n: re_ni};

  hcif_sync #(.W($bits(strobe_t)), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pins),
    .q_o   (strb_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) strb_q <= '1;
    else         strb_q <= strb_s;
  end

  logic legacy, we_rise, ce_rise, wr_commit;
  assign legacy  = ~strb_s.re_n;
  assign we_rise = strb_s.we_n & ~strb_q.we_n;
  assign ce_rise = strb_s.ce_n & ~strb_q.ce_n;
  // normal: write strobe trailing edge; legacy: select trailing edge with R/W low
  assign wr_commit = (~legacy & ~strb_s.ce_n & we_rise)
                   | ( legacy & ~strb_s.we_n & ce_rise);

  assign oe_o = ~strb_s.ce_n & ~strb_s.re_n & strb_s.we_n;

  akind_e           kind;
  logic [IDX_W-1:0] idx;

  hcif_decode #(.AW(AW), .N_CTRL(N_CTRL), .N_DC(N_DC), .IDX_W(IDX_W)) u_dec (
    .addr_i(addr_i),
    .kind_o(kind),
    .idx_o (idx)
  );

  hcif_regfile #(.DW(DW), .N_CTRL(N_CTRL), .N_DC(N_DC), .IDX_W(IDX_W)) u_rf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr_commit),
    .kind_i (kind),
    .idx_i  (idx),
    .wdata_i(wdata_i),
    .ctrl_o (ctrl_regs_o),
    .dc_o   (dc_regs_o)
  );

  assign cap_addr_o = addr_i[MW-1:0];

  hcif_rdmux #(.DW(DW), .N_CTRL(N_CTRL), .N_DC(N_DC), .IDX_W(IDX_W)) u_rd (
    .oe_i   (oe_o),
    .kind_i (kind),
    .idx_i  (idx),
    .ctrl_i (ctrl_regs_o),
    .dc_i   (dc_regs_o),
    .test_i (test_stat_i),
    .mem_i  (cap_rdata_i),
    .rdata_o(rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pulse_o     <= 1'b0;
      lut_we_o    <= 1'b0;
      lut_addr_o  <= '0;
      lut_wdata_o <= '0;
    end else begin
      pulse_o  <= wr_commit && kind == K_PULSE;
      lut_we_o <= wr_commit && kind == K_MEM;
      if (wr_commit && kind == K_MEM) begin
        lut_addr_o  <= addr_i[MW-1:0];
        lut_wdata_o <= wdata_i;
      end
    end
  end
endmodule

// File: rtl/hcif_chk.sv
module hcif_chk #(
  parameter int DW     = 16,
  parameter int AW     = 9,
  parameter int N_CTRL = 14,
  parameter int N_DC   = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 ce_ni,
  input logic                 we_ni,
  input logic                 re_ni,
  input logic [AW-1:0]        addr_i,
  input logic [DW-1:0]        rdata_o,
  input logic                 oe_o,
  input logic [N_CTRL*DW-1:0] ctrl_regs_o,
  input logic [N_DC*DW-1:0]   dc_regs_o,
  input logic                 pulse_o,
  input logic                 lut_we_o,
  input logic [DW-1:0]        test_stat_i,
  input logic [DW-1:0]        cap_rdata_i,
  input logic                 wr_commit
);
  localparam logic [AW-1:0] TEST_A = AW'(N_CTRL + 1);
  localparam logic [AW-1:0] FREE_A = AW'(N_CTRL + 2 + N_DC);

  logic [1:0] cyc_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cyc_q <= '0;
    else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
  end

  p_oe_sync_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q == 2'd3) |-> (oe_o == ($past(!ce_ni, 2) && $past(!re_ni, 2) && $past(we_ni, 2))));

  p_rdata_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_o |-> (rdata_o == '0));

  p_pulse_width_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);

  p_pulse_cause_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |-> $past(wr_commit));

  p_test_read_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_o && addr_i == TEST_A) |-> (rdata_o == test_stat_i));

  p_unused_read_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_o && !addr_i[AW-1] && addr_i >= FREE_A) |-> (rdata_o == '0));

  p_lut_width_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lut_we_o |=> !lut_we_o);

  p_cap_read_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_o && addr_i[AW-1]) |-> (rdata_o == cap_rdata_i));

  p_regs_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(wr_commit) |-> ($stable(ctrl_regs_o) && $stable(dc_regs_o)));
endmodule

bind host_ctrl_if hcif_chk #(.DW(DW), .AW(AW), .N_CTRL(N_CTRL), .N_DC(N_DC)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ce_ni      (ce_ni),
  .we_ni      (we_ni),
  .re_ni      (re_ni),
  .addr_i     (addr_i),
  .rdata_o    (rdata_o),
  .oe_o       (oe_o),
  .ctrl_regs_o(ctrl_regs_o),
  .dc_regs_o  (dc_regs_o),
  .pulse_o    (pulse_o),
  .lut_we_o   (lut_we_o),
  .test_stat_i(test_stat_i),
  .cap_rdata_i(cap_rdata_i),
  .wr_commit  (wr_commit)
);

// File: tb/tb_host_ctrl_if.sv
module tb_host_ctrl_if;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] TSTAT = 16'hC3C3;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         ce_ni = 1'b1, we_ni = 1'b1, re_ni = 1'b1;
  logic [8:0]   addr_i = '0;
  logic [15:0]  wdata_i = '0;
  logic [15:0]  rdata_o;
  logic         oe_o, pulse_o, lut_we_o;
  logic [223:0] ctrl_regs_o;
  logic [63:0]  dc_regs_o;
  logic [7:0]   lut_addr_o, cap_addr_o;
  logic [15:0]  lut_wdata_o, cap_rdata_i;

  assign cap_rdata_i = {8'hA5, cap_addr_o};

  always #(CLK_PERIOD/2) clk = ~clk;

  host_ctrl_if dut (
    .clk_i(clk), .rst_ni(rst_ni), .ce_ni(ce_ni), .we_ni(we_ni), .re_ni(re_ni),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .oe_o(oe_o),
    .ctrl_regs_o(ctrl_regs_o), .dc_regs_o(dc_regs_o), .pulse_o(pulse_o),
    .test_stat_i(TSTAT), .lut_we_o(lut_we_o), .lut_addr_o(lut_addr_o),
    .lut_wdata_o(lut_wdata_o), .cap_addr_o(cap_addr_o), .cap_rdata_i(cap_rdata_i)
  );

  int checks = 0, errors = 0;
  int pulse_cnt = 0, lut_cnt = 0;
  logic [7:0]  lut_a;
  logic [15:0] lut_d;

  always @(negedge clk) if (rst_ni) begin
    if (pulse_o) pulse_cnt++;
    if (lut_we_o) begin lut_cnt++; lut_a = lut_addr_o; lut_d = lut_wdata_o; end
  end

  // {addr, write data, expected read}
  localparam logic [40:0] VEC [10] = '{
    {9'd0,   16'h1234, 16'h1234},
    {9'd7,   16'h00FF, 16'h00FF},
    {9'd13,  16'hBEEF, 16'hBEEF},
    {9'd14,  16'h5555, 16'h0000},
    {9'd15,  16'h9999, TSTAT},
    {9'd16,  16'h0A0A, 16'h0A0A},
    {9'd19,  16'hF00F, 16'hF00F},
    {9'd20,  16'h4444, 16'h0000},
    {9'd255, 16'h6666, 16'h0000},
    {9'd300, 16'h7777, 16'hA52C}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_norm(input logic [8:0] a, input logic [15:0] d);
    addr_i = a; wdata_i = d; re_ni = 1'b1; ce_ni = 1'b0; we_ni = 1'b0;
    cyc(4);
    we_ni = 1'b1;
    cyc(5);
    ce_ni = 1'b1;
    cyc(2);
  endtask

  task automatic rd_norm(input logic [8:0] a, output logic [15:0] d, output logic oe);
    addr_i = a; we_ni = 1'b1; ce_ni = 1'b0; re_ni = 1'b0;
    cyc(4);
    d = rdata_o; oe = oe_o;
    ce_ni = 1'b1; re_ni = 1'b1;
    cyc(4);
  endtask

  task automatic wr_leg(input logic [8:0] a, input logic [15:0] d);
    re_ni = 1'b0; ce_ni = 1'b1; we_ni = 1'b0; addr_i = a; wdata_i = d;
    cyc(3);
    ce_ni = 1'b0;
    cyc(4);
    ce_ni = 1'b1;
    cyc(5);
  endtask

  task automatic rd_leg(input logic [8:0] a, output logic [15:0] d);
    re_ni = 1'b0; ce_ni = 1'b1; we_ni = 1'b1; addr_i = a;
    cyc(3);
    ce_ni = 1'b0;
    cyc(4);
    d = rdata_o;
    ce_ni = 1'b1;
    cyc(5);
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    logic oe;
    logic [223:0] c_snap;
    logic [63:0]  d_snap;

    cyc(3);
    chk(ctrl_regs_o == '0 && dc_regs_o == '0, "R11 regs after reset", 32'(ctrl_regs_o[31:0]), 0);
    chk(!oe_o && !pulse_o && !lut_we_o, "R11 outputs after reset", {oe_o, pulse_o, lut_we_o}, 0);
    rst_ni = 1'b1;
    cyc(3);

    // table walk: write all, then read all
    for (int i = 0; i < 10; i++) wr_norm(VEC[i][40:32], VEC[i][31:16]);
    for (int i = 0; i < 10; i++) begin
      rd_norm(VEC[i][40:32], rd, oe);
      chk(oe && rd == VEC[i][15:0], "R1/R4-R10 table read", rd, VEC[i][15:0]);
    end
    chk(ctrl_regs_o[13*16 +: 16] == 16'hBEEF, "R4 ctrl word 13 port", ctrl_regs_o[13*16 +: 16], 16'hBEEF);
    chk(ctrl_regs_o[7*16 +: 16] == 16'h00FF, "R4 ctrl word 7 port", ctrl_regs_o[7*16 +: 16], 16'h00FF);
    chk(dc_regs_o[0 +: 16] == 16'h0A0A, "R7 dc I in port", dc_regs_o[0 +: 16], 16'h0A0A);
    chk(dc_regs_o[3*16 +: 16] == 16'hF00F, "R7 dc Q out port", dc_regs_o[3*16 +: 16], 16'hF00F);

    // R5 pulse width and no storage
    c_snap = ctrl_regs_o; d_snap = dc_regs_o; pulse_cnt = 0;
    wr_norm(9'd14, 16'hFFFF);
    chk(pulse_cnt == 1, "R5 pulse one cycle", pulse_cnt, 1);
    chk(ctrl_regs_o == c_snap && dc_regs_o == d_snap, "R5 nothing stored", 0, 0);

    // R6 / R8 writes ignored
    wr_norm(9'd15, 16'h1111);
    wr_norm(9'd100, 16'h2222);
    chk(ctrl_regs_o == c_snap && dc_regs_o == d_snap, "R6/R8 writes ignored", 0, 0);
    rd_norm(9'd15, rd, oe);
    chk(rd == TSTAT, "R6 test status read", rd, TSTAT);
    rd_norm(9'd100, rd, oe);
    chk(rd == 16'h0, "R8 unused read zero", rd, 0);

    // R9 lookup write
    lut_cnt = 0;
    wr_norm(9'h1A7, 16'h7E57);
    chk(lut_cnt == 1, "R9 lut_we one cycle", lut_cnt, 1);
    chk(lut_a == 8'hA7 && lut_d == 16'h7E57, "R9 lut addr/data", {lut_a, lut_d}, {8'hA7, 16'h7E57});
    chk(ctrl_regs_o == c_snap && dc_regs_o == d_snap, "R9 no register change", 0, 0);
    rd_norm(9'h100, rd, oe);
    chk(rd == 16'hA500, "R10 capture read offset 0", rd, 16'hA500);
    rd_norm(9'h1FF, rd, oe);
    chk(rd == 16'hA5FF, "R10 capture read offset 255", rd, 16'hA5FF);

    // R3 output-enable rules
    addr_i = 9'd20; ce_ni = 1'b0; re_ni = 1'b0; we_ni = 1'b0; cyc(4);
    chk(!oe_o && rdata_o == 0, "R3 we low no drive", oe_o, 0);
    ce_ni = 1'b1; we_ni = 1'b1; cyc(4);
    chk(!oe_o, "R3 ce high no drive", oe_o, 0);
    ce_ni = 1'b0; re_ni = 1'b1; cyc(4);
    chk(!oe_o && rdata_o == 0, "R3 re high no drive", oe_o, 0);
    ce_ni = 1'b1; cyc(4);

    // R2 legacy mode
    wr_leg(9'd5, 16'h0F5A);
    chk(ctrl_regs_o[5*16 +: 16] == 16'h0F5A, "R2 legacy write", ctrl_regs_o[5*16 +: 16], 16'h0F5A);
    wr_leg(9'd17, 16'h3C3C);
    rd_leg(9'd17, rd);
    chk(rd == 16'h3C3C, "R2 legacy read dc Q in", rd, 16'h3C3C);
    c_snap = ctrl_regs_o;
    rd_leg(9'd5, rd);
    chk(rd == 16'h0F5A && ctrl_regs_o == c_snap, "R2 legacy read no write", rd, 16'h0F5A);
    re_ni = 1'b1; cyc(3);

    // R11 reset mid-run
    rst_ni = 1'b0; cyc(2);
    chk(ctrl_regs_o == '0 && dc_regs_o == '0, "R11 reset clears", 32'(ctrl_regs_o[31:0]), 0);
    chk(!oe_o && !pulse_o && !lut_we_o, "R11 reset outputs low", {oe_o, pulse_o, lut_we_o}, 0);
    rst_ni = 1'b1; cyc(2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule